// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block sits in front of a frequency synthesizer's divider and phase detector logic. A host shifts 18-bit words into it on a three-wire interface (serial clock, serial data, load strobe). On each rising edge of the load strobe, the word's least significant bit picks one of two internal registers, and the upper 17 bits are written into it. One register holds the reference divide ratio and the detector controls. The other holds the swallow (A) and programmable (B) counts and a 2-bit control word.

The serial pins are sampled with the block's own clock. Each pin passes through a small synchronizer and an edge detector, so only the logical order of the serial events matters.

From the control word and the chip-enable pin, the block derives the power state of the dividers and detector:
- normal operation;
- counter clear;
- a synchronous power-down that waits until the current charge-pump pulse has ended;
- an asynchronous power-down that acts at once.

Pulling chip-enable low forces the asynchronous power-down at once, whatever the register holds. The serial path keeps working in every power state.

A reference ratio below the legal minimum is refused: the previous ratio is kept and a sticky error flag is raised.

Top module: `sreg_loader`

## Requirements
- R1: Serial data is shifted MSB first on each rising edge of `ser_clk` into an 18-bit register. A loaded word consists of the last 18 bits shifted, and any earlier bits are discarded.
- R2: On a rising edge of `ser_le`, bit 0 of the word selects the target register: 1 writes the reference register and 0 writes the feedback register. The register that is not selected keeps its contents.
- R3: Reference word fields: bits 10:1 hold the divide ratio, bit 11 the charge-pump tri-state, bit 12 the detector polarity (1 = positive) and bit 14 the test mode. Bits 13 and 17:15 have no effect on any output.
- R4: Feedback word fields: bit 1 is the power-down bit, bit 2 the counter-reset bit, bits 7:3 the A count and bits 17:8 the B count.
- R5: A reference word whose ratio is below 2 leaves the ratio unchanged and sets `ratio_err`. The flag stays set until reset. The word's other reference fields are still written.
- R6: After reset, every register output is zero (ratio 0, negative polarity, normal mode, no error), and `cnt_clear`, `pd_sync`, `pd_async` and `pwr_down` are 0 while `chip_en` is high.
- R7: Control word {reset, power-down} = 00 gives normal operation: `cnt_clear`, `pd_sync`, `pd_async` and `pwr_down` are all 0.
- R8: Control word 10 gives counter clear: `cnt_clear` is 1 and no power-down output is set.
- R9: Control word 11 gives asynchronous power-down: `pd_async`, `pwr_down` and `cnt_clear` are 1 from the same cycle in which the fields appear.
- R10: Control word 01 gives synchronous power-down. `pd_sync` stays 0 while `pump_busy` is high, and becomes 1 in the cycle after `pump_busy` is seen low. While `pd_sync` is 1, `pwr_down` and `cnt_clear` are 1.
- R11: `chip_en` low sets `pd_async`, `pwr_down` and `cnt_clear` without waiting for a clock edge, whatever the control word. Raising `chip_en` returns the block to the programmed state.
- R12: Words shifted and loaded during any power-down state are written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock (rising edge shifts) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe (rising edge writes a register) |
| chip_en | input | 1 | Chip enable; low forces asynchronous power-down |
| pump_busy | input | 1 | High while a charge-pump pulse is in progress |
| ref_ratio | output | 10 | Reference divide ratio |
| a_count | output | 5 | Swallow (A) count |
| b_count | output | 10 | Programmable (B) count |
| pd_polarity | output | 1 | Detector polarity, 1 = positive |
| cp_tristate | output | 1 | Charge-pump tri-state request |
| test_mode | output | 1 | Divider output test mode |
| ratio_err | output | 1 | Sticky flag: an illegal ratio was refused |
| cnt_clear | output | 1 | Hold the dividers at their load point |
| pd_sync | output | 1 | Synchronous power-down in effect |
| pd_async | output | 1 | Asynchronous power-down in effect |
| pwr_down | output | 1 | Any power-down in effect |

## Verification
The following properties are checked by assertions on every cycle:
- a load strobe is a single-cycle pulse;
- the registers change only on a load;
- the ratio only ever takes legal values, and the error flag is sticky;
- the synchronous power-down never starts while a pump pulse is in progress;
- a low chip-enable always produces the asynchronous power-down.

Other behaviours can only be shown by the bench's scenarios:
- the bit order and field positions, checked over a sweep of all A counts and of many ratios;
- the refusal of ratios 0 and 1;
- the deferred start of the synchronous power-down;
- the loading of words while the block is powered down.

// File: rtl/sreg_loader_pkg.sv
package sreg_loader_pkg;
    localparam int WORD_W    = 18;
    localparam int RATIO_W   = 10;
    localparam int ACNT_W    = 5;
    localparam int BCNT_W    = 10;
    localparam int MIN_RATIO = 2;

    // field positions inside the shifted word
    localparam int RATIO_LSB = 1;
    localparam int TRI_BIT   = 11;
    localparam int POL_BIT   = 12;
    localparam int TEST_BIT  = 14;
    localparam int PD_BIT    = 1;
    localparam int CRST_BIT  = 2;
    localparam int ACNT_LSB  = 3;
    localparam int BCNT_LSB  = ACNT_LSB + ACNT_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               tri_st;
        logic               pol;
        logic               test;
        logic               err;
    } ref_regs_t;

    typedef struct packed {
        logic [BCNT_W-1:0] bcnt;
        logic [ACNT_W-1:0] acnt;
        logic              crst;
        logic              pd;
    } fb_regs_t;

    // control word {counter reset, power-down}
    typedef enum logic [1:0] {
        CTL_RUN      = 2'b00,
        CTL_SYNC_PD  = 2'b01,
        CTL_CLEAR    = 2'b10,
        CTL_ASYNC_PD = 2'b11
    } ctl_mode_e;
endpackage

// File: rtl/sload_shifter.sv
module sload_shifter
    import sreg_loader_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int SYNC  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         ser_le,
    output logic         ld_o,
    output logic [W-1:0] word_o
);
    localparam int TOP = SYNC - 1;

    typedef struct packed {
        logic [SYNC-1:0] ck_sync;
        logic [SYNC-1:0] dat_sync;
        logic [SYNC-1:0] le_sync;
        logic            ck_prev;
        logic            le_prev;
        logic [W-1:0]    sh;
    } shf_state_t;

    shf_state_t st_d, st_q;
    logic ck_rise, le_rise;

    always_comb begin
        st_d          = st_q;
        st_d.ck_sync  = {st_q.ck_sync[TOP-1:0],  ser_clk};
        st_d.dat_sync = {st_q.dat_sync[TOP-1:0], ser_data};
        st_d.le_sync  = {st_q.le_sync[TOP-1:0],  ser_le};
        st_d.ck_prev  = st_q.ck_sync[TOP];
        st_d.le_prev  = st_q.le_sync[TOP];
        ck_rise       = st_q.ck_sync[TOP] & ~st_q.ck_prev;
        le_rise       = st_q.le_sync[TOP] & ~st_q.le_prev;
        if (ck_rise)
            st_d.sh = {st_q.sh[W-2:0], st_q.dat_sync[TOP]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ld_o   = le_rise;
    assign word_o = st_q.sh;

    // R2
    ld_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_o |=> !ld_o);
    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_rise |=> $stable(st_q.sh));
endmodule

// File: rtl/sload_regs.sv
module sload_regs
    import sreg_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [WORD_W-1:0] word_i,
    output ref_regs_t         ref_o,
    output fb_regs_t          fb_o
);
    typedef struct packed {
        ref_regs_t r;
        fb_regs_t  f;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic [RATIO_W-1:0] new_ratio;
    logic               ign_unused;

    assign new_ratio  = word_i[RATIO_LSB +: RATIO_W];
    assign ign_unused = ^{word_i[WORD_W-1:TEST_BIT+1], word_i[TEST_BIT-1]};

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            if (word_i[0]) begin
                st_d.r.tri_st = word_i[TRI_BIT];
                st_d.r.pol    = word_i[POL_BIT];
                st_d.r.test   = word_i[TEST_BIT];
                if (new_ratio >= RATIO_W'(MIN_RATIO))
                    st_d.r.ratio = new_ratio;
                else
                    st_d.r.err = 1'b1;
            end else begin
                st_d.f.pd   = word_i[PD_BIT];
                st_d.f.crst = word_i[CRST_BIT];
                st_d.f.acnt = word_i[ACNT_LSB +: ACNT_W];
                st_d.f.bcnt = word_i[BCNT_LSB +: BCNT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_o = st_q.r;
    assign fb_o  = st_q.f;

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.r.err |=> st_q.r.err);
    // R5
    ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.r.ratio) |-> st_q.r.ratio >= RATIO_W'(MIN_RATIO));
    // R2
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(st_q.f));
    // R2
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(st_q.r));
endmodule

// File: rtl/sload_power.sv
module sload_power
    import sreg_loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en,
    input  logic pump_busy,
    input  logic crst_i,
    input  logic pd_i,
    output logic pd_sync_o,
    output logic pd_async_o,
    output logic cnt_clear_o,
    output logic pwr_down_o
);
    typedef struct packed {
        logic sync_pd;
    } pwr_state_t;

    pwr_state_t st_d, st_q;
    ctl_mode_e  mode;

    assign mode = ctl_mode_e'({crst_i, pd_i});

    always_comb begin
        st_d         = st_q;
        st_d.sync_pd = (mode == CTL_SYNC_PD) && (st_q.sync_pd || !pump_busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd_async_o  = !chip_en || (mode == CTL_ASYNC_PD);
    assign pd_sync_o   = st_q.sync_pd;
    assign pwr_down_o  = pd_async_o || pd_sync_o;
    assign cnt_clear_o = pwr_down_o || (mode == CTL_CLEAR);

    // R10
    sync_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sync_pd) |-> !$past(pump_busy));
    // R11
    ce_forces_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (pd_async_o && cnt_clear_o));
    // R10
    pd_holds_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_o |-> cnt_clear_o);
endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
    import sreg_loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_le,
    input  logic               chip_en,
    input  logic               pump_busy,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic [ACNT_W-1:0]  a_count,
    output logic [BCNT_W-1:0]  b_count,
    output logic               pd_polarity,
    output logic               cp_tristate,
    output logic               test_mode,
    output logic               ratio_err,
    output logic               cnt_clear,
    output logic               pd_sync,
    output logic               pd_async,
    output logic               pwr_down
);
    logic              ld;
    logic [WORD_W-1:0] word;
    ref_regs_t         refr;
    fb_regs_t          fbr;

    sload_shifter #(.W(WORD_W), .SYNC(2)) u_shf (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .ld_o(ld), .word_o(word)
    );

    sload_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .word_i(word),
        .ref_o(refr), .fb_o(fbr)
    );

    sload_power u_pwr (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pump_busy(pump_busy),
        .crst_i(fbr.crst), .pd_i(fbr.pd), .pd_sync_o(pd_sync),
        .pd_async_o(pd_async), .cnt_clear_o(cnt_clear), .pwr_down_o(pwr_down)
    );

    assign ref_ratio   = refr.ratio;
    assign pd_polarity = refr.pol;
    assign cp_tristate = refr.tri_st;
    assign test_mode   = refr.test;
    assign ratio_err   = refr.err;
    assign a_count     = fbr.acnt;
    assign b_count     = fbr.bcnt;
endmodule

// File: tb/sim_sreg_loader.sv
module sim_sreg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic chip_en = 1'b1, pump_busy = 1'b0;
    logic [9:0] ref_ratio, b_count;
    logic [4:0] a_count;
    logic pd_polarity, cp_tristate, test_mode, ratio_err;
    logic cnt_clear, pd_sync, pd_async, pwr_down;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sreg_loader u0 (.*);

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    // shift n bits of v, MSB first, then pulse the load strobe
    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wclk(2);
            ser_clk = 1'b1;
            wclk(2);
            ser_clk = 1'b0;
        end
        wclk(2);
        ser_le = 1'b1;
        wclk(3);
        ser_le = 1'b0;
        wclk(5);
    endtask

    function automatic logic [17:0] ref_w(logic [9:0] r, logic t, logic p, logic tm,
                                          logic rsv, logic [2:0] dc);
        return {dc, tm, rsv, p, t, r, 1'b1};
    endfunction

    function automatic logic [17:0] fb_w(logic [9:0] b, logic [4:0] a, logic [1:0] ctl);
        return {b, a, ctl, 1'b0};
    endfunction

    task automatic chk_pwr(string tag, int ea, int es, int ec);
        chk({tag, " pd_async"}, pd_async, ea);
        chk({tag, " pd_sync"}, pd_sync, es);
        chk({tag, " cnt_clear"}, cnt_clear, ec);
        chk({tag, " pwr_down"}, pwr_down, (ea | es));
    endtask

    initial begin
        int exp_ratio;
        wclk(4);
        rst_n = 1'b1;
        wclk(2);
        // R6 reset state
        chk("R6 ratio", ref_ratio, 0);
        chk("R6 a", a_count, 0);
        chk("R6 b", b_count, 0);
        chk("R6 pol", pd_polarity, 0);
        chk("R6 tri", cp_tristate, 0);
        chk("R6 test", test_mode, 0);
        chk("R6 err", ratio_err, 0);
        chk_pwr("R6", 0, 0, 0);

        // R4 R7 R8 R9 R10: sweep all A counts with rotating control words
        for (int a = 0; a < 32; a++) begin
            int b = (a * 37 + 100) % 1024;
            int ctl = a % 4;
            send(fb_w(b[9:0], a[4:0], ctl[1:0]), 18);
            chk("R4 a", a_count, a);
            chk("R4 b", b_count, b);
            chk_pwr("R7-9 ctl", (ctl == 3), (ctl == 1), (ctl != 0));
            chk("R2 ratio untouched", ref_ratio, 0);
        end

        // R3 R5: sweep legal ratios with varied flags and ignored bits
        for (int r = 2; r < 72; r++) begin
            send(ref_w(r[9:0], r[0], r[1], r[2], r[3], r[6:4]), 18);
            chk("R3 ratio", ref_ratio, r);
            chk("R3 tri", cp_tristate, r % 2);
            chk("R3 pol", pd_polarity, (r / 2) % 2);
            chk("R3 test", test_mode, (r / 4) % 2);
            chk("R5 err clear", ratio_err, 0);
        end
        exp_ratio = 71;
        chk("R2 fb untouched", a_count, 31);

        // R5: illegal ratios refused, other fields written, flag sticky
        send(ref_w(10'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0), 18);
        chk("R5 ratio kept", ref_ratio, exp_ratio);
        chk("R5 err", ratio_err, 1);
        chk("R5 pol written", pd_polarity, 1);
        send(ref_w(10'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0), 18);
        chk("R5 ratio kept 0", ref_ratio, exp_ratio);
        chk("R5 tri written", cp_tristate, 1);
        send(ref_w(10'd1023, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0), 18);
        chk("R5 max ratio", ref_ratio, 1023);
        chk("R5 err sticky", ratio_err, 1);

        // R1: extra leading bits are pushed out, MSB first
        send({2'b11, fb_w(10'd555, 5'd9, 2'b00)}, 20);
        chk("R1 b", b_count, 555);
        chk("R1 a", a_count, 9);

        // R10: synchronous power-down waits for the pump pulse to end
        pump_busy = 1'b1;
        send(fb_w(10'd600, 5'd3, 2'b01), 18);
        wclk(6);
        chk_pwr("R10 pending", 0, 0, 0);
        pump_busy = 1'b0;
        wclk(2);
        chk_pwr("R10 active", 0, 1, 1);
        pump_busy = 1'b1;
        wclk(2);
        chk("R10 held", pd_sync, 1);
        pump_busy = 1'b0;

        // R12: loading continues while powered down
        send(fb_w(10'd700, 5'd17, 2'b11), 18);
        chk("R12 b under pd", b_count, 700);
        chk_pwr("R9", 1, 0, 1);
        send(fb_w(10'd701, 5'd18, 2'b00), 18);
        chk_pwr("R7 back", 0, 0, 0);

        // R11: chip enable low, seen before any clock edge
        @(posedge clk);
        #1 chip_en = 1'b0;
        #0.5;
        chk_pwr("R11 ce low", 1, 0, 1);
        wclk(1);
        send(fb_w(10'd802, 5'd21, 2'b10), 18);
        chk("R12 a under ce", a_count, 21);
        chk("R12 b under ce", b_count, 802);
        chk_pwr("R11 still low", 1, 0, 1);
        chip_en = 1'b1;
        #0.5;
        chk_pwr("R11 ce high R8", 0, 0, 1);
        wclk(2);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule